// File: doc/BRIEF.md
# Boost LED Driver Fault Supervisor

This block watches the protection comparators of a two-channel boost LED driver and decides, once per switching cycle, whether each channel may switch. Its inputs are the comparator flags, the PWM dimming input, a soft-start-done flag, a standby enable and a one-cycle tick marking the start of each switching period. Every fault class has its own debounce rule: some cut switching at once, some count ticks before latching off, and one changes its qualifying condition partway through its count.

After a timer latch-off the block drives an active-low fault output, forces the dimming switches off and asks the soft-start capacitor to discharge. A long auto-restart count then runs. When it expires the block issues a restart request pulse and rearms only if every fault flag has gone quiet. Pulling standby low clears everything. Any start, including one after an auto-restart, waits for a rising PWM edge.

The controller has four states. OFF is held while standby is low. WAIT is armed and waiting for a PWM rising edge. RUN is switching. LATCH is the latched-off state. The transitions are: power-up (OFF→WAIT on standby high), start (WAIT→RUN on PWM rise), trip (RUN→LATCH when any fault timer expires), rearm (LATCH→WAIT on restart expiry with no fault active), and shutdown (any state→OFF while standby is low).

Top module: `fltsup_ctrl`

## Requirements
- R1: While running, an active over-voltage flag drives every gate-enable low and every dim_lo high in the same cycle.
- R2: While running, an active LED over-current flag on a channel drives that channel's gate-enable low and its dim_hi high, without waiting for PWM.
- R3: When over-voltage and LED over-current are both active, dim_hi stays low and dim_lo is high, because over-voltage has priority.
- R4: Over-voltage or LED over-current held through DEB_TICKS (4) consecutive ticks latches the block off. If the flag drops earlier, its count restarts from zero and switching continues.
- R5: Over-boost is ignored while ss_done is low. After that, fb_high together with pwm high for OB_QUAL (4) ticks arms a second count. From then on only fb_high is needed, and latch-off follows OB_TICKS further ticks.
- R6: cs_lo seen outside blanking drops that channel's gate-enable until the next tick, without latching and without touching fail_n.
- R7: cs_hi seen outside blanking in DEB_TICKS consecutive switching cycles latches the block off. Fewer cycles do not.
- R8: For BLANK_CYC clock cycles starting with the cycle in which gate_drv rises, both cs_lo and cs_hi are ignored on that channel.
- R9: While latched, fail_n is 0, all gate-enables are 0, all dim_lo are 1 and ss_dis is 1.
- R10: In LATCH, after RST_TICKS ticks restart_req pulses high for one cycle. The block moves to WAIT if no fault flag is active, and otherwise stays latched and counts again.
- R11: stby_en low forces OFF from any state: fail_n goes to 1 and the latch and restart count are cleared. After standby returns high, switching starts only on a PWM rising edge.
- R12: Gate-enables are 1 only in RUN, and ss_dis is 1 in every state except RUN. Out of reset, fail_n is 1 and restart_req is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stby_en | input | 1 | Standby enable; low shuts down and clears the latch |
| pwm | input | 1 | PWM dimming input |
| ss_done | input | 1 | Soft start has completed |
| tick | input | 1 | One-cycle pulse per switching period |
| ovp | input | 1 | Output over-voltage comparator flag |
| led_ocp | input | NCH | LED over-current flag per channel |
| fb_high | input | NCH | Error-amplifier output above over-boost level per channel |
| cs_lo | input | NCH | Inductor current above the cycle-limit level per channel |
| cs_hi | input | NCH | Inductor current above the latch level per channel |
| gate_drv | input | NCH | Gate drive state per channel, used to start blanking |
| gate_en | output | NCH | Gate enable per channel |
| dim_lo | output | NCH | Force dimming switch off per channel |
| dim_hi | output | NCH | Force dimming switch on per channel |
| fail_n | output | 1 | Latched fault, active low |
| restart_req | output | 1 | One-cycle auto-restart request |
| ss_dis | output | 1 | Soft-start discharge request |

## Verification
Every cycle, the assertions check the following. Over-voltage holds all gates off and keeps dim_hi low. A latched block keeps its gates off and its dimming switches forced low. Standby always leads to a cleared, non-switching block. A blanked channel never sets its cut flag. Over-boost cannot trip without soft-start completion. The restart pulse comes only out of the latched state. The debounce counters never run past their limit. Only the bench scenarios can show the exact tick counts at which each fault class trips or does not trip: the early clear of a debounce count, the switch of the over-boost count from PWM-qualified to fb-only, and whether auto-restart rearms or stays latched depending on the fault flags. They also show that a restart waits for a fresh PWM edge.

// File: rtl/fltsup_pkg.sv
package fltsup_pkg;
    typedef enum logic [1:0] {
        ST_OFF,
        ST_WAIT,
        ST_RUN,
        ST_LATCH
    } sup_state_t;
endpackage

// File: rtl/fltsup_deb.sv
// Tick debounce counter: counts ticks while 'active' holds, clears otherwise.
module fltsup_deb #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic active,
    input  logic tick,
    output logic done
);
    localparam int W = $clog2(LIMIT + 1);
    localparam logic [W-1:0] LIM_V = W'(LIMIT);

    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr || !active)
            cnt <= '0;
        else if (tick && cnt != LIM_V)
            cnt <= cnt + 1'b1;
    end

    assign done = (cnt == LIM_V);

    // R4: the debounce count never passes its limit
    a_r4_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LIM_V);
    // R4: a dropped flag restarts the count
    a_r4_clear_on_drop: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> cnt == '0);
endmodule

// File: rtl/fltsup_cs.sv
// Per-channel current-sense handling: leading-edge blanking, cycle cut, high-level debounce.
module fltsup_cs #(
    parameter int BLANK_CYC = 75,
    parameter int DEB_TICKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    input  logic gate_drv,
    input  logic cs_lo,
    input  logic cs_hi,
    output logic cut,
    output logic hit
);
    localparam int BW = $clog2(BLANK_CYC + 1);
    localparam logic [BW-1:0] BLOAD = BW'(BLANK_CYC - 1);
    localparam int HW = $clog2(DEB_TICKS + 1);
    localparam logic [HW-1:0] HLIM = HW'(DEB_TICKS);

    logic          gate_q;
    logic [BW-1:0] bcnt;
    logic          rise, blank, eff_lo, eff_hi;
    logic          cut_q, seen_q;
    logic [HW-1:0] hcnt;

    assign rise   = gate_drv && !gate_q;
    assign blank  = rise || (bcnt != '0);
    assign eff_lo = cs_lo && !blank;
    assign eff_hi = cs_hi && !blank;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gate_q <= 1'b0;
            bcnt   <= '0;
        end else begin
            gate_q <= gate_drv;
            if (rise)
                bcnt <= BLOAD;
            else if (bcnt != '0)
                bcnt <= bcnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cut_q  <= 1'b0;
            seen_q <= 1'b0;
            hcnt   <= '0;
        end else if (clr) begin
            cut_q  <= 1'b0;
            seen_q <= 1'b0;
            hcnt   <= '0;
        end else if (tick) begin
            cut_q  <= 1'b0;
            seen_q <= 1'b0;
            if (seen_q || eff_hi) begin
                if (hcnt != HLIM)
                    hcnt <= hcnt + 1'b1;
            end else begin
                hcnt <= '0;
            end
        end else begin
            cut_q  <= cut_q || eff_lo || eff_hi;
            seen_q <= seen_q || eff_hi;
        end
    end

    assign cut = cut_q || eff_lo || eff_hi;
    assign hit = (hcnt == HLIM);

    // R8: a blanked cycle never sets the cut flag
    a_r8_blank_no_cut: assert property (@(posedge clk) disable iff (!rst_n)
        (blank && !cut_q) |=> !cut_q);
    // R6: a cut never survives a tick
    a_r6_cut_ends_at_tick: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !cut_q);
endmodule

// File: rtl/fltsup_obmon.sv
// Over-boost monitor: PWM-qualified arming count, then fb-only latch count.
module fltsup_obmon #(
    parameter int QUAL  = 4,
    parameter int LIMIT = 16384
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic ss_done,
    input  logic pwm,
    input  logic fb_high,
    input  logic tick,
    output logic hit
);
    localparam int MAXV = (LIMIT > QUAL) ? LIMIT : QUAL;
    localparam int W = $clog2(MAXV + 1);
    localparam logic [W-1:0] QLAST = W'(QUAL - 1);
    localparam logic [W-1:0] LIM_V = W'(LIMIT);

    logic         armed;
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed <= 1'b0;
            cnt   <= '0;
        end else if (clr || !ss_done || !fb_high) begin
            armed <= 1'b0;
            cnt   <= '0;
        end else if (!armed) begin
            if (!pwm)
                cnt <= '0;
            else if (tick) begin
                if (cnt == QLAST) begin
                    armed <= 1'b1;
                    cnt   <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end else if (tick && cnt != LIM_V) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign hit = armed && (cnt == LIM_V);

    // R5: over-boost cannot trip before soft start completes
    a_r5_masked: assert property (@(posedge clk) disable iff (!rst_n)
        !ss_done |=> !hit);
endmodule

// File: rtl/fltsup_ctrl.sv
module fltsup_ctrl #(
    parameter int NCH       = 2,
    parameter int DEB_TICKS = 4,
    parameter int OB_QUAL   = 4,
    parameter int OB_TICKS  = 16384,
    parameter int RST_TICKS = 131072,
    parameter int BLANK_CYC = 75
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           stby_en,
    input  logic           pwm,
    input  logic           ss_done,
    input  logic           tick,
    input  logic           ovp,
    input  logic [NCH-1:0] led_ocp,
    input  logic [NCH-1:0] fb_high,
    input  logic [NCH-1:0] cs_lo,
    input  logic [NCH-1:0] cs_hi,
    input  logic [NCH-1:0] gate_drv,
    output logic [NCH-1:0] gate_en,
    output logic [NCH-1:0] dim_lo,
    output logic [NCH-1:0] dim_hi,
    output logic           fail_n,
    output logic           restart_req
    ,
    output logic           ss_dis
);
    import fltsup_pkg::*;

    localparam int RW = $clog2(RST_TICKS + 1);
    localparam logic [RW-1:0] RLAST = RW'(RST_TICKS - 1);

    sup_state_t     state, nxt;
    logic           pwm_q, pwm_rise, run, sub_clr;
    logic           ovp_hit, trip, raw_fault, rst_evt;
    logic [NCH-1:0] led_hit, cs_hit, ob_hit, cut;
    logic [RW-1:0]  rcnt;

    assign run      = (state == ST_RUN);
    assign sub_clr  = !run;
    assign pwm_rise = pwm && !pwm_q;

    fltsup_deb #(.LIMIT(DEB_TICKS)) u_ovp_deb (
        .clk(clk), .rst_n(rst_n), .clr(sub_clr), .active(ovp),
        .tick(tick), .done(ovp_hit)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        fltsup_deb #(.LIMIT(DEB_TICKS)) u_led_deb (
            .clk(clk), .rst_n(rst_n), .clr(sub_clr), .active(led_ocp[c]),
            .tick(tick), .done(led_hit[c])
        );
        fltsup_cs #(.BLANK_CYC(BLANK_CYC), .DEB_TICKS(DEB_TICKS)) u_cs (
            .clk(clk), .rst_n(rst_n), .clr(sub_clr), .tick(tick),
            .gate_drv(gate_drv[c]), .cs_lo(cs_lo[c]), .cs_hi(cs_hi[c]),
            .cut(cut[c]), .hit(cs_hit[c])
        );
        fltsup_obmon #(.QUAL(OB_QUAL), .LIMIT(OB_TICKS)) u_ob (
            .clk(clk), .rst_n(rst_n), .clr(sub_clr), .ss_done(ss_done),
            .pwm(pwm), .fb_high(fb_high[c]), .tick(tick), .hit(ob_hit[c])
        );
    end

    assign trip      = ovp_hit || (|led_hit) || (|cs_hit) || (|ob_hit);
    assign raw_fault = ovp || (|led_ocp) || (|cs_hi) || (|fb_high);
    assign rst_evt   = (state == ST_LATCH) && tick && (rcnt == RLAST);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_OFF;
        else
            state <= nxt;
    end

    // Next-state decode
    always_comb begin
        nxt = state;
        unique case (state)
            ST_OFF:   if (stby_en)                nxt = ST_WAIT;
            ST_WAIT:  if (pwm_rise)               nxt = ST_RUN;
            ST_RUN:   if (trip)                   nxt = ST_LATCH;
            ST_LATCH: if (rst_evt && !raw_fault)  nxt = ST_WAIT;
            default:                              nxt = ST_OFF;
        endcase
        if (!stby_en)
            nxt = ST_OFF;
    end

    // PWM edge tracker, auto-restart counter and request pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pwm_q       <= 1'b0;
            rcnt        <= '0;
            restart_req <= 1'b0;
        end else begin
            pwm_q       <= pwm;
            restart_req <= rst_evt;
            if (state != ST_LATCH)
                rcnt <= '0;
            else if (tick)
                rcnt <= (rcnt == RLAST) ? '0 : rcnt + 1'b1;
        end
    end

    // Outputs
    always_comb begin
        fail_n = (state != ST_LATCH);
        ss_dis = !run;
        for (int c = 0; c < NCH; c++) begin
            gate_en[c] = run && !ovp && !led_ocp[c] && !cut[c];
            dim_lo[c]  = (run && ovp) || (state == ST_LATCH);
            dim_hi[c]  = run && !ovp && led_ocp[c];
        end
    end

    // R1: over-voltage never lets a gate switch
    a_r1_ovp_gates_off: assert property (@(posedge clk) disable iff (!rst_n)
        ovp |-> gate_en == '0);
    // R3: over-voltage outranks LED over-current on the dimming override
    a_r3_ovp_priority: assert property (@(posedge clk) disable iff (!rst_n)
        ovp |-> dim_hi == '0);
    // R9: latched outputs
    a_r9_latched_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        !fail_n |-> (gate_en == '0 && dim_lo == '1 && ss_dis));
    // R11: standby clears the latch and stops switching
    a_r11_standby_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !stby_en |=> (fail_n && gate_en == '0 && ss_dis));
    // R10: restart pulse comes only out of the latched state
    a_r10_req_from_latch: assert property (@(posedge clk) disable iff (!rst_n)
        restart_req |-> $past(state == ST_LATCH));
    // R12: switching only in RUN
    a_r12_gate_only_run: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> gate_en == '0);
endmodule

// File: tb/fltsup_ctrl_tb.sv
module fltsup_ctrl_tb;
    localparam int NCH = 2;
    localparam int DEB = 4;
    localparam int QUAL = 4;
    localparam int OBT = 20;
    localparam int RST = 40;
    localparam int BLK = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stby_en = 1'b0, pwm = 1'b0, ss_done = 1'b0, tick = 1'b0, ovp = 1'b0;
    logic [NCH-1:0] led_ocp = '0, fb_high = '0, cs_lo = '0, cs_hi = '0, gate_drv = '1;
    logic [NCH-1:0] gate_en, dim_lo, dim_hi;
    logic fail_n, restart_req, ss_dis;

    int checks = 0;
    int errors = 0;
    int req_seen = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    fltsup_ctrl #(
        .NCH(NCH), .DEB_TICKS(DEB), .OB_QUAL(QUAL), .OB_TICKS(OBT),
        .RST_TICKS(RST), .BLANK_CYC(BLK)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .stby_en(stby_en), .pwm(pwm), .ss_done(ss_done),
        .tick(tick), .ovp(ovp), .led_ocp(led_ocp), .fb_high(fb_high),
        .cs_lo(cs_lo), .cs_hi(cs_hi), .gate_drv(gate_drv), .gate_en(gate_en),
        .dim_lo(dim_lo), .dim_hi(dim_hi), .fail_n(fail_n),
        .restart_req(restart_req), .ss_dis(ss_dis)
    );

    always @(negedge clk) if (rst_n && restart_req) req_seen++;

    function automatic logic [NCH-1:0] exp_gate(input logic o, input logic [NCH-1:0] l);
        return o ? '0 : ~l;
    endfunction
    function automatic logic [NCH-1:0] exp_dlo(input logic o);
        return o ? '1 : '0;
    endfunction
    function automatic logic [NCH-1:0] exp_dhi(input logic o, input logic [NCH-1:0] l);
        return o ? '0 : l;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_tick(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic start_run();
        pwm = 1'b0; cyc(1);
        pwm = 1'b1; cyc(1);
    endtask

    task automatic standby_cycle();
        stby_en = 1'b0; cyc(2);
        stby_en = 1'b1; cyc(2);
        start_run();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog (all requirements): actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        pwm = 1'b1;
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        // R12 reset state
        check("R12 reset fail_n", 32'(fail_n), 1);
        check("R12 reset gate_en", 32'(gate_en), 0);
        check("R12 reset ss_dis", 32'(ss_dis), 1);
        check("R12 reset restart_req", 32'(restart_req), 0);

        // R11: standby high with PWM already high does not start
        stby_en = 1'b1; cyc(4);
        check("R11 no start without pwm edge", 32'(gate_en), 0);
        start_run();
        check("R11 start on pwm edge", 32'(gate_en), 3);
        check("R12 ss_dis low in run", 32'(ss_dis), 0);

        // R4/R1: over-voltage for 3 ticks, then clear, twice
        for (int k = 0; k < 2; k++) begin
            ovp = 1'b1;
            do_tick(3);
            check("R1 ovp gates off", 32'(gate_en), 0);
            check("R1 ovp dim_lo", 32'(dim_lo), 3);
            ovp = 1'b0; cyc(1);
            check("R4 early clear keeps running", 32'(gate_en), 3);
            check("R4 early clear no latch", 32'(fail_n), 1);
        end

        // R1/R2/R3: random flag patterns without ticks
        for (int i = 0; i < 200; i++) begin
            ovp = 1'($urandom);
            led_ocp = NCH'($urandom);
            fb_high = NCH'($urandom);
            pwm = 1'($urandom);
            #1;
            check("R1/R2 gate_en", 32'(gate_en), 32'(exp_gate(ovp, led_ocp)));
            check("R1/R3 dim_lo", 32'(dim_lo), 32'(exp_dlo(ovp)));
            check("R2/R3 dim_hi", 32'(dim_hi), 32'(exp_dhi(ovp, led_ocp)));
            @(negedge clk);
        end
        ovp = 1'b0; led_ocp = '0; fb_high = '0; pwm = 1'b1;
        cyc(1);

        // R8/R6: cs_lo inside blanking ignored, outside it cuts until next tick
        gate_drv[1] = 1'b0; cyc(1);
        gate_drv[1] = 1'b1; cs_lo[1] = 1'b1; #1;
        check("R8 blank rise cycle", 32'(gate_en[1]), 1);
        cyc(1);
        check("R8 blank cycle 2", 32'(gate_en[1]), 1);
        cyc(1);
        check("R8 blank cycle 3", 32'(gate_en[1]), 1);
        cyc(1);
        check("R6 cs_lo cuts after blanking", 32'(gate_en[1]), 0);
        cyc(1);
        cs_lo[1] = 1'b0; #1;
        check("R6 cut held until tick", 32'(gate_en[1]), 0);
        @(negedge clk);
        do_tick(1);
        check("R6 next cycle resumes", 32'(gate_en[1]), 1);
        check("R6 no fault latch", 32'(fail_n), 1);

        // R7/R8: cs_hi only inside blanking over many cycles
        for (int k = 0; k < 6; k++) begin
            gate_drv[1] = 1'b0; cyc(1);
            gate_drv[1] = 1'b1; cs_hi[1] = 1'b1; cyc(1);
            cs_hi[1] = 1'b0; cyc(2);
            do_tick(1);
        end
        check("R8 blanked cs_hi no latch", 32'(fail_n), 1);

        // R7: unblanked cs_hi, 3 then 4 cycles
        cs_hi[1] = 1'b1;
        do_tick(3);
        check("R7 three cycles no latch", 32'(fail_n), 1);
        do_tick(1); cyc(2);
        check("R7 four cycles latch", 32'(fail_n), 0);
        check("R9 gates off", 32'(gate_en), 0);
        check("R9 dim_lo forced", 32'(dim_lo), 3);
        check("R9 ss_dis", 32'(ss_dis), 1);

        // R10: restart with fault still active stays latched
        do_tick(RST); cyc(2);
        check("R10 one restart pulse", 32'(req_seen), 1);
        check("R10 fault active stays latched", 32'(fail_n), 0);
        cs_hi[1] = 1'b0;
        do_tick(RST); cyc(2);
        check("R10 second restart pulse", 32'(req_seen), 2);
        check("R10 rearm when clear", 32'(fail_n), 1);
        check("R10 waits for pwm edge", 32'(gate_en), 0);
        start_run();
        check("R10 resumes on pwm edge", 32'(gate_en), 3);

        // R4/R11: over-voltage latch, standby clears
        ovp = 1'b1;
        do_tick(4); cyc(2);
        check("R4 ovp latch", 32'(fail_n), 0);
        ovp = 1'b0; stby_en = 1'b0; cyc(1);
        check("R11 standby clears latch", 32'(fail_n), 1);
        check("R11 standby ss_dis", 32'(ss_dis), 1);
        stby_en = 1'b1; cyc(3);
        check("R11 needs pwm edge", 32'(gate_en), 0);
        start_run();
        check("R11 restarted", 32'(gate_en), 3);

        // R4/R2: LED over-current latch on channel 0
        led_ocp = 2'b01;
        do_tick(3);
        check("R2 led ocp ch0 dim_hi", 32'(dim_hi), 1);
        check("R4 led ocp three ticks", 32'(fail_n), 1);
        do_tick(1); cyc(2);
        check("R4 led ocp latch", 32'(fail_n), 0);
        led_ocp = '0;
        standby_cycle();

        // R5: over-boost masking, qualification and fb-only count
        ss_done = 1'b0; fb_high = 2'b01; pwm = 1'b1;
        do_tick(8);
        check("R5 masked before soft start", 32'(fail_n), 1);
        ss_done = 1'b1; pwm = 1'b0;
        do_tick(30);
        check("R5 needs pwm to arm", 32'(fail_n), 1);
        pwm = 1'b1;
        do_tick(QUAL);
        pwm = 1'b0;
        do_tick(OBT - 1);
        check("R5 one tick short", 32'(fail_n), 1);
        do_tick(1); cyc(2);
        check("R5 over-boost latch", 32'(fail_n), 0);
        fb_high = '0;
        standby_cycle();
        check("R11 clean restart", 32'(gate_en), 3);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule